// File: doc/BRIEF.md
# Edge-Skew Binary Dot-Product Chain

This block computes the sign of a binarized dot product plus a per-channel offset without ever holding the running sum as a number. A launcher sends one rising edge down each of two pulse lines, A and B, at the same moment. A chain of identical synchronous stages then shifts the two lines apart. Each stage forms the XNOR of its stored weight bit and its activation bit. A match (+1) delays A by one clock and B by two. A mismatch (−1) delays A by two and B by one. When the edges reach the end of the chain, the gap from the A edge to the B edge equals the signed sum. A detector at the end looks at A on each rising edge of B and returns one result bit with a valid strobe.

The lowest `NUM_ACT` stages take the caller's activations. The top `NUM_OFS` stages take a fixed +1 activation, so their weight bits encode the channel's batch-norm offset as a sum of ±1 terms. Every stage holds its own copy of the activation vector, which travels along with the pulse pair. As a result, the next pulse pair may enter the chain before the previous one has left it. The result bits, taken in raster order, also feed a 2x2 stride-2 max-pool over a feature map `MAP_W` results wide. For binary values this max-pool is the OR of the window.

Both programmed lengths must be large enough for the chain. The pulse high time must be at least STAGES+1 cycles, and the low time must be at least STAGES+4 cycles.

Top module: `tdc_dot_chain`

## Requirements
- R1: Logic 1 encodes +1 and logic 0 encodes −1. Each accepted launch produces one result, and `resBit` is 1 exactly when S = Σ over activation stages of XNOR(wt[i], act[i]) + Σ over offset stages of wt[j] is ≥ 0, where each term counts as +1 for logic 1 and −1 for logic 0.
- R2: A total S of exactly zero gives `resBit` = 1. A total of −2 gives `resBit` = 0.
- R3: Weight bits [STAGES-1:NUM_ACT] belong to the offset stages. Each of these stages is fed a +1 activation, so together they add Σ(±1) of those bits to S.
- R4: `resValid` is high for a single cycle. It rises 2 + STAGES + K clock edges after the edge that accepts the launch, where K is the number of stages whose XNOR is 1.
- R5: `ready` drops on the edge after an accepted `start`. When `start` is held high, two accepted launches are exactly holdLen + gapLen + 2 edges apart.
- R6: A `start` that is asserted while `ready` is low is ignored and produces no result.
- R7: Results are taken in raster order across a map `MAP_W` wide. On an odd row, after each odd column, `poolValid` pulses and `poolBit` carries the OR of that 2x2 window.
- R8: `wtIn` is captured only on a cycle with `wtLoad` high and is then held. Weights may change only while no pulse is in the chain.
- R9: After reset, `ready` is 1 and `resValid` and `poolValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wtLoad | input | 1 | Capture `wtIn` into the weight register |
| wtIn | input | NUM_ACT+NUM_OFS | Per-stage weight bits; the upper bits are the offset stages |
| start | input | 1 | Request a launch; accepted only while `ready` is high |
| actIn | input | NUM_ACT | Activation bits, captured when the launch is accepted |
| holdLen | input | CNT_W | Number of cycles the launched pulse stays high |
| gapLen | input | CNT_W | Number of cycles the launched pulse stays low afterwards |
| ready | output | 1 | Launcher is idle and can accept `start` |
| resBit | output | 1 | Sign of dot product plus offset (1 = non-negative) |
| resValid | output | 1 | One-cycle strobe that marks a new `resBit` |
| poolBit | output | 1 | OR of the finished 2x2 window |
| poolValid | output | 1 | One-cycle strobe that marks a new `poolBit` |

## Verification
Several input patterns are used, each to tell a different fault apart:

- **All matches and all mismatches.** These drive the skew to its two extremes. They separate a swapped delay pair from a correct one, and they also check the hold and gap margins.
- **Totals of exactly zero and −2.** These sit on either side of the detector threshold, so a detector that samples A one cycle late or early shows up.
- **Changes to the offset bits alone.** These show whether the offset stages really see a +1 activation.
- **Random weights with back-to-back launches.** Weights are reloaded between groups while `wtIn` is left scrambled. This shows that activation vectors stay attached to their own pulse pair, and that weights are taken only on `wtLoad`.

The arrival cycle of each result is compared against the count of matching stages. The pooled stream is compared against the OR of the expected results.

// File: rtl/tdc_chain_pkg.sv
package tdc_chain_pkg;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_ARM,
    LS_HIGH,
    LS_LOW
  } launch_state_e;

  // strobes from launcher control into the chain datapath
  typedef struct packed {
    logic latchAct;
    logic lineHi;
  } launch_strb_t;

endpackage

// File: rtl/tdc_launch_ctrl.sv
module tdc_launch_ctrl
  import tdc_chain_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] holdLen,
  input  logic [CNT_W-1:0] gapLen,
  output logic             ready,
  output launch_strb_t     strb
);

  launch_state_e    state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ready         = (state == LS_IDLE);
    strb.latchAct = (state == LS_IDLE) && start;
    strb.lineHi   = (state == LS_HIGH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= LS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        LS_IDLE: if (start) state <= LS_ARM;
        LS_ARM: begin
          state <= LS_HIGH;
          cnt   <= holdLen - 1'b1;
        end
        LS_HIGH: begin
          if (cnt == '0) begin
            state <= LS_LOW;
            cnt   <= gapLen - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        LS_LOW: begin
          if (cnt == '0) state <= LS_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= LS_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    ready && start |=> !ready); // R6

  AST_READY_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(!strb.lineHi)); // R5

endmodule

// File: rtl/tdc_stage.sv
module tdc_stage #(
  parameter int STAGES = 16,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wBit,
  input  logic [STAGES-1:0] vecIn,
  output logic [STAGES-1:0] vecOut,
  input  logic              aIn,
  input  logic              bIn,
  output logic              aOut,
  output logic              bOut
);

  logic [STAGES-1:0] vecQ;
  logic aD1, aD2, bD1, bD2;
  logic quiet, xx;

  // the stage takes a new activation vector only while no edge is inside it
  assign quiet  = !(aIn || bIn || aD1 || aD2 || bD1 || bD2);
  assign xx     = ~(wBit ^ vecQ[IDX]);
  assign aOut   = xx ? aD1 : aD2;
  assign bOut   = xx ? bD2 : bD1;
  assign vecOut = vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= '0;
      aD1  <= 1'b0;
      aD2  <= 1'b0;
      bD1  <= 1'b0;
      bD2  <= 1'b0;
    end else begin
      aD1 <= aIn;
      aD2 <= aD1;
      bD1 <= bIn;
      bD2 <= bD1;
      if (quiet) vecQ <= vecIn;
    end
  end

  AST_XX_STABLE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (aOut || bOut) && $past(aOut || bOut) |-> $stable(xx)); // R1

endmodule

// File: rtl/tdc_chain_dp.sv
module tdc_chain_dp
  import tdc_chain_pkg::*;
#(
  parameter int NUM_ACT = 12,
  parameter int NUM_OFS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wtLoad,
  input  logic [NUM_ACT+NUM_OFS-1:0] wtIn,
  input  logic [NUM_ACT-1:0]         actIn,
  input  launch_strb_t               strb,
  output logic                       resBit,
  output logic                       resValid
);

  localparam int STAGES = NUM_ACT + NUM_OFS;

  logic [STAGES-1:0] wtQ;
  logic [STAGES-1:0] actQ;
  logic [STAGES-1:0] actFull;
  logic [STAGES-1:0] vecBus [STAGES+1];
  logic              aLine  [STAGES+1];
  logic              bLine  [STAGES+1];
  logic              bPrev;

  // offset stages see a constant +1 activation
  always_comb begin
    actFull              = '1;
    actFull[NUM_ACT-1:0] = actIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wtQ  <= '0;
      actQ <= '0;
    end else begin
      if (wtLoad)        wtQ  <= wtIn;
      if (strb.latchAct) actQ <= actFull;
    end
  end

  assign vecBus[0] = actQ;
  assign aLine[0]  = strb.lineHi;
  assign bLine[0]  = strb.lineHi;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    tdc_stage #(.STAGES(STAGES), .IDX(g)) stage_i (
      .clk    (clk),
      .rstN   (rstN),
      .wBit   (wtQ[g]),
      .vecIn  (vecBus[g]),
      .vecOut (vecBus[g+1]),
      .aIn    (aLine[g]),
      .bIn    (bLine[g]),
      .aOut   (aLine[g+1]),
      .bOut   (bLine[g+1])
    );
  end

  // sign detector: look at A when B rises at the chain end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bPrev    <= 1'b0;
      resValid <= 1'b0;
      resBit   <= 1'b0;
    end else begin
      bPrev    <= bLine[STAGES];
      resValid <= bLine[STAGES] && !bPrev;
      if (bLine[STAGES] && !bPrev) resBit <= aLine[STAGES];
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R4

endmodule

// File: rtl/tdc_maxpool.sv
module tdc_maxpool #(
  parameter int MAP_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic resBit,
  input  logic resValid,
  output logic poolBit,
  output logic poolValid
);

  localparam int COL_W = $clog2(MAP_W);

  logic [COL_W-1:0] colIdx;
  logic             rowOdd;
  logic             pairAcc;
  logic [MAP_W-1:0] lineBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colIdx    <= '0;
      rowOdd    <= 1'b0;
      pairAcc   <= 1'b0;
      lineBuf   <= '0;
      poolBit   <= 1'b0;
      poolValid <= 1'b0;
    end else begin
      poolValid <= 1'b0;
      if (resValid) begin
        if (!colIdx[0]) begin
          pairAcc <= resBit;
        end else if (!rowOdd) begin
          lineBuf[colIdx] <= pairAcc | resBit;
        end else begin
          poolBit   <= pairAcc | resBit | lineBuf[colIdx];
          poolValid <= 1'b1;
        end
        if (colIdx == COL_W'(MAP_W - 1)) begin
          colIdx <= '0;
          rowOdd <= ~rowOdd;
        end else begin
          colIdx <= colIdx + 1'b1;
        end
      end
    end
  end

  AST_POOL_ODD_ROW: assert property (@(posedge clk) disable iff (!rstN)
    poolValid |-> $past(resValid) && $past(rowOdd)); // R7

endmodule

// File: rtl/tdc_dot_chain.sv
module tdc_dot_chain
  import tdc_chain_pkg::*;
#(
  parameter int NUM_ACT = 12,
  parameter int NUM_OFS = 4,
  parameter int CNT_W   = 8,
  parameter int MAP_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wtLoad,
  input  logic [NUM_ACT+NUM_OFS-1:0] wtIn,
  input  logic                       start,
  input  logic [NUM_ACT-1:0]         actIn,
  input  logic [CNT_W-1:0]           holdLen,
  input  logic [CNT_W-1:0]           gapLen,
  output logic                       ready,
  output logic                       resBit,
  output logic                       resValid,
  output logic                       poolBit,
  output logic                       poolValid
);

  launch_strb_t strb;

  tdc_launch_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .holdLen (holdLen),
    .gapLen  (gapLen),
    .ready   (ready),
    .strb    (strb)
  );

  tdc_chain_dp #(.NUM_ACT(NUM_ACT), .NUM_OFS(NUM_OFS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wtLoad   (wtLoad),
    .wtIn     (wtIn),
    .actIn    (actIn),
    .strb     (strb),
    .resBit   (resBit),
    .resValid (resValid)
  );

  tdc_maxpool #(.MAP_W(MAP_W)) pool_i (
    .clk       (clk),
    .rstN      (rstN),
    .resBit    (resBit),
    .resValid  (resValid),
    .poolBit   (poolBit),
    .poolValid (poolValid)
  );

endmodule

// File: tb/tdc_dot_chain_tb_top.sv
module tdc_dot_chain_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 12;
  localparam int NO = 4;
  localparam int M  = NA + NO;
  localparam int CW = 8;
  localparam int MW = 4;
  localparam int HOLD = 20;
  localparam int GAP  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wtLoad = 1'b0;
  logic [M-1:0] wtIn = '0;
  logic start = 1'b0;
  logic [NA-1:0] actIn = '0;
  logic [CW-1:0] holdLen = CW'(HOLD);
  logic [CW-1:0] gapLen = CW'(GAP);
  logic ready, resBit, resValid, poolBit, poolValid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastAcc = -1;
  bit done = 0;
  logic [M-1:0] curW = '0;

  bit    expRes[$];
  int    expCyc[$];
  string expTag[$];
  bit    expPool[$];

  int pCol = 0;
  bit pRowOdd = 0;
  bit pPair = 0;
  bit pLine[MW];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdc_dot_chain #(.NUM_ACT(NA), .NUM_OFS(NO), .CNT_W(CW), .MAP_W(MW)) dut_i (
    .clk(clk), .rstN(rstN), .wtLoad(wtLoad), .wtIn(wtIn), .start(start),
    .actIn(actIn), .holdLen(holdLen), .gapLen(gapLen), .ready(ready),
    .resBit(resBit), .resValid(resValid), .poolBit(poolBit), .poolValid(poolValid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic poolModel(input bit r);
    if (pCol % 2 == 0) pPair = r;
    else if (!pRowOdd) pLine[pCol] = pPair | r;
    else expPool.push_back(pPair | r | pLine[pCol]);
    pCol++;
    if (pCol == MW) begin
      pCol = 0;
      pRowOdd = !pRowOdd;
    end
  endtask

  task automatic loadW(input logic [M-1:0] w);
    @(negedge clk);
    wtIn = w; wtLoad = 1'b1; curW = w;
    @(negedge clk);
    wtLoad = 1'b0; wtIn = ~w;  // scrambled, must be ignored (R8)
  endtask

  task automatic launch(input logic [NA-1:0] a, input string tag, input bit b2b);
    int ones = 0;
    int acc;
    int sum;
    @(negedge clk);
    while (!ready) @(negedge clk);
    actIn = a; start = 1'b1; acc = cyc + 1;
    for (int i = 0; i < NA; i++) ones += (curW[i] ~^ a[i]) ? 1 : 0;
    for (int j = NA; j < M; j++) ones += curW[j] ? 1 : 0;
    sum = 2 * ones - M;
    expRes.push_back(sum >= 0);
    expCyc.push_back(acc + 2 + M + ones);
    expTag.push_back(tag);
    poolModel(sum >= 0);
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R5 ready after accept", int'(ready), 0);
    if (b2b && lastAcc >= 0) chk(acc - lastAcc == HOLD + GAP + 2, "R5 spacing", acc - lastAcc, HOLD + GAP + 2);
    lastAcc = acc;
    actIn = ~a; start = 1'b1;  // R6: poke while busy
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expRes.size() != 0) @(negedge clk);
    repeat (HOLD + GAP + 2 * M + 10) @(negedge clk);
    lastAcc = -1;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (expRes.size() == 0) begin
          chk(1'b0, "R6 unexpected result", int'(resBit), -1);
        end else begin
          bit e;
          int ec;
          string t;
          e = expRes.pop_front(); ec = expCyc.pop_front(); t = expTag.pop_front();
          chk(resBit == e, t, int'(resBit), int'(e));
          chk(cyc == ec, "R4 latency", cyc, ec);
        end
      end
      if (poolValid) begin
        if (expPool.size() == 0) chk(1'b0, "R7 unexpected pool", int'(poolBit), -1);
        else begin
          bit ep;
          ep = expPool.pop_front();
          chk(poolBit == ep, "R7 pool", int'(poolBit), int'(ep));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9 ready", int'(ready), 1);
    chk(resValid == 1'b0, "R9 resValid", int'(resValid), 0);
    chk(poolValid == 1'b0, "R9 poolValid", int'(poolValid), 0);

    loadW(16'hFFFF);
    launch(12'hFFF, "R1 all match", 1'b0);
    launch(12'h000, "R1 all mismatch", 1'b1);
    drain();
    loadW(16'h3FFF);  // offset 0
    launch(12'h03F, "R2 sum zero", 1'b0);
    launch(12'h01F, "R2 sum minus two", 1'b1);
    drain();
    loadW(16'h0FFF);  // offset -4
    launch(12'h0FF, "R3 offset zero total", 1'b0);
    launch(12'h07F, "R3 offset negative", 1'b1);
    drain();
    for (int g = 0; g < 4; g++) begin
      loadW(M'($urandom));
      for (int k = 0; k < 6; k++) launch(NA'($urandom), "R8 random", k != 0);
      drain();
    end
    chk(expRes.size() == 0, "R1 results outstanding", expRes.size(), 0);
    chk(expPool.size() == 0, "R7 pool outstanding", expPool.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule